// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory request into a stream of per-element byte addresses. A single start pulse captures a base address, an element count, an element width and an addressing mode; the sequencer then hands out one address per accepted output transfer. Each address is tagged with its element number. Memory, data movement and translation checks are handled elsewhere.

Three address patterns come from the same engine. In the contiguous pattern, elements sit back to back. In the strided pattern, a scalar stride counted in elements is scaled to bytes. In the gather/scatter pattern, each element's byte offset is pulled, in order, from a streamed index input that uses a ready/valid handshake. A count of zero completes at once. A count above the hardware maximum is cut to that maximum. A single-cycle completion pulse ends every request.

The control is a four-state machine. ST_IDLE waits for start. ST_FETCH waits for the next index and is used only in gather/scatter. ST_ISSUE presents an address. ST_FINISH raises the completion pulse. Its transitions are:
- ST_IDLE to ST_FINISH on start with a zero count.
- ST_IDLE to ST_FETCH on start in gather/scatter.
- ST_IDLE to ST_ISSUE on any other start.
- ST_FETCH to ST_ISSUE when an index is accepted.
- ST_ISSUE to ST_ISSUE on an accepted address that is not the last, in a non-indexed pattern.
- ST_ISSUE to ST_FETCH on an accepted address that is not the last, in gather/scatter.
- ST_ISSUE to ST_FINISH on the accepted last address.
- ST_FINISH to ST_IDLE unconditionally.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset, addr_valid, idx_ready and done are all low.
- R2: With mode 2'b00, element i is issued at base + i*size. The size in bytes is 1, 2, 4 or 8 for ewidth 0, 1, 2 or 3.
- R3: With mode 2'b01, element i is issued at base + i*stride*size. The stride is a two's-complement element count, and the arithmetic wraps modulo 2^ADDR_W.
- R4: With mode 2'b10, element i is issued at base + idx_i. Here idx_i is the i-th index value accepted on idx_data, read as a byte offset. idx_ready is high only while the block waits for an index, never in the same cycle as addr_valid, and never in the other modes.
- R5: A request issues exactly min(vlen, MAXVL) addresses, with addr_elem running 0, 1, 2 and so on in order. At most one address is accepted per cycle.
- R6: A request with vlen 0 issues no address and raises done in the cycle after the start edge.
- R7: done is high for exactly one cycle, and that cycle follows the edge at which the last address is accepted.
- R8: While addr_valid is high and addr_ready is low, addr_valid, addr_out and addr_elem hold their values.
- R9: A start pulse arriving while a request is in progress is ignored, along with the inputs presented with it.
- R10: mode 2'b11 behaves as the contiguous pattern.
- R11: A vlen above MAXVL is treated as MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| mode | input | 2 | 00 contiguous, 01 strided, 10 gather/scatter, 11 contiguous |
| ewidth | input | 2 | Element size select: 1, 2, 4 or 8 bytes |
| base | input | ADDR_W | Base byte address |
| stride | input | ADDR_W | Stride in elements (two's complement) |
| vlen | input | VL_W | Element count |
| idx_valid | input | 1 | Index value present |
| idx_data | input | ADDR_W | Index byte offset |
| idx_ready | output | 1 | Block accepts an index |
| addr_valid | output | 1 | Address present |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_out | output | ADDR_W | Element byte address |
| addr_elem | output | VL_W | Element number of addr_out |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the corner cases that break this sequencer. A zero count would either hang or emit a stray address. A count above the maximum would run past it. A negative stride would expose a design that does not sign-extend or wrap. A count of one would test off-by-one end detection, which would show up as an extra or missing address. Output stalls combined with gaps on the index stream would catch a design that advances without a handshake or moves the address while it is held. A start pulse injected mid-request, carrying different parameters, would catch a design that restarts or re-captures its configuration.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [1:0] {
        MODE_UNIT     = 2'b00,
        MODE_STRIDE   = 2'b01,
        MODE_INDEX    = 2'b10,
        MODE_UNIT_ALT = 2'b11
    } vag_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE,
        ST_FINISH
    } vag_state_e;

endpackage

// File: rtl/vag_step_calc.sv
module vag_step_calc #(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        mode,
    input  logic [1:0]        ewidth,
    input  logic [ADDR_W-1:0] stride,
    output logic [ADDR_W-1:0] step
);
    import vag_pkg::*;

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (vag_mode_e'(mode) == MODE_STRIDE) begin
            step = stride << ewidth;
        end else begin
            step = ONE << ewidth;
        end
    end

endmodule

// File: rtl/vag_ctrl.sv
module vag_ctrl #(
    parameter int MAXVL = 64,
    parameter int VL_W  = $clog2(MAXVL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VL_W-1:0] vlen_in,
    input  logic            indexed_in,
    input  logic            idx_valid,
    input  logic            addr_ready,
    output logic            capture,
    output logic            idx_take,
    output logic            step_adv,
    output logic            idx_ready,
    output logic            addr_valid,
    output logic            done,
    output logic [VL_W-1:0] elem
);
    import vag_pkg::*;

    localparam logic [VL_W-1:0] MAXVL_C = VL_W'(MAXVL);
    localparam logic [VL_W-1:0] ONE_C   = VL_W'(1);

    vag_state_e      state_q, state_d;
    logic [VL_W-1:0] elem_q, vl_q, vl_eff;
    logic            indexed_q;
    logic            last;

    assign vl_eff = (vlen_in > MAXVL_C) ? MAXVL_C : vlen_in;
    assign last   = (elem_q == vl_q - ONE_C);
    assign elem   = elem_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (vl_eff == '0)    state_d = ST_FINISH;
                    else if (indexed_in) state_d = ST_FETCH;
                    else                 state_d = ST_ISSUE;
                end
            end
            ST_FETCH: begin
                if (idx_valid) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (addr_ready) begin
                    if (last)           state_d = ST_FINISH;
                    else if (indexed_q) state_d = ST_FETCH;
                    else                state_d = ST_ISSUE;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        idx_ready  = (state_q == ST_FETCH);
        addr_valid = (state_q == ST_ISSUE);
        done       = (state_q == ST_FINISH);
        capture    = (state_q == ST_IDLE) && start;
        idx_take   = (state_q == ST_FETCH) && idx_valid;
        step_adv   = (state_q == ST_ISSUE) && addr_ready && !last && !indexed_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elem_q    <= '0;
            vl_q      <= '0;
            indexed_q <= 1'b0;
        end else if (capture) begin
            elem_q    <= '0;
            vl_q      <= vl_eff;
            indexed_q <= indexed_in;
        end else if (addr_valid && addr_ready && !last) begin
            elem_q    <= elem_q + ONE_C;
        end
    end

    // R8: a stalled element keeps its valid and its number
    a_r8_hold_elem: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready |=> addr_valid && $stable(elem_q));
    // R7: completion pulse lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: index handshake and address handshake never overlap
    a_r4_idx_excl: assert property (@(posedge clk) disable iff (!rst_n)
        idx_ready |-> !addr_valid);
    // R5: element number stays below the captured count
    a_r5_elem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> elem_q < vl_q);
    // R5: element number advances by one after each accepted non-final address
    a_r5_elem_step: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && addr_ready && !last |=> elem_q == $past(elem_q) + ONE_C);
    // R6: a zero-length request completes in the next cycle
    a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        capture && vl_eff == '0 |=> done);

endmodule

// File: rtl/vag_addr_dp.sv
module vag_addr_dp #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              idx_take,
    input  logic              step_adv,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] step_in,
    input  logic [ADDR_W-1:0] idx_data,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q, base_q, step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            base_q <= '0;
            step_q <= '0;
        end else if (capture) begin
            addr_q <= base_in;
            base_q <= base_in;
            step_q <= step_in;
        end else if (idx_take) begin
            addr_q <= base_q + idx_data;
        end else if (step_adv) begin
            addr_q <= addr_q + step_q;
        end
    end

    assign addr = addr_q;

    // R4: an accepted index lands as base plus offset
    a_r4_idx_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_take && !capture |=> addr_q == base_q + $past(idx_data));

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int MAXVL  = 64,
    parameter int VL_W   = $clog2(MAXVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [1:0]        ewidth,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [VL_W-1:0]   vlen,
    input  logic              idx_valid,
    input  logic [ADDR_W-1:0] idx_data,
    output logic              idx_ready,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr_out,
    output logic [VL_W-1:0]   addr_elem,
    output logic              done
);
    import vag_pkg::*;

    logic              capture, idx_take, step_adv, indexed_in;
    logic [ADDR_W-1:0] step;

    assign indexed_in = (vag_mode_e'(mode) == MODE_INDEX);

    vag_step_calc #(.ADDR_W(ADDR_W)) u_step (
        .mode   (mode),
        .ewidth (ewidth),
        .stride (stride),
        .step   (step)
    );

    vag_ctrl #(.MAXVL(MAXVL), .VL_W(VL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vlen_in    (vlen),
        .indexed_in (indexed_in),
        .idx_valid  (idx_valid),
        .addr_ready (addr_ready),
        .capture    (capture),
        .idx_take   (idx_take),
        .step_adv   (step_adv),
        .idx_ready  (idx_ready),
        .addr_valid (addr_valid),
        .done       (done),
        .elem       (addr_elem)
    );

    vag_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .idx_take (idx_take),
        .step_adv (step_adv),
        .base_in  (base),
        .step_in  (step),
        .idx_data (idx_data),
        .addr     (addr_out)
    );

    // R8: a stalled address does not move
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready |=> $stable(addr_out));
    // R9: a busy sequencer never captures a new request
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid || idx_ready) |-> !capture);
    // R7: done never coincides with a presented address
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid && !idx_ready);

endmodule

// File: tb/test_vec_addr_gen.sv
module test_vec_addr_gen;

    localparam int AW = 32;
    localparam int VW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [1:0]    ewidth = 2'b00;
    logic [AW-1:0] base = '0;
    logic [AW-1:0] stride = '0;
    logic [VW-1:0] vlen = '0;
    logic          idx_valid = 1'b0;
    logic [AW-1:0] idx_data = '0;
    logic          idx_ready;
    logic          addr_valid;
    logic          addr_ready = 1'b0;
    logic [AW-1:0] addr_out;
    logic [VW-1:0] addr_elem;
    logic          done;

    int n_checks = 0;
    int n_errors = 0;
    logic [AW-1:0] idx_mem [64];

    always #10 clk = ~clk;

    vec_addr_gen i_vec_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ewidth(ewidth),
        .base(base), .stride(stride), .vlen(vlen), .idx_valid(idx_valid),
        .idx_data(idx_data), .idx_ready(idx_ready), .addr_valid(addr_valid),
        .addr_ready(addr_ready), .addr_out(addr_out), .addr_elem(addr_elem),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One request; checks every address, element number, stall hold and done timing.
    task automatic run_case(input string req, input logic [1:0] md, input logic [1:0] ew,
                            input logic [AW-1:0] bs, input logic [AW-1:0] sd,
                            input logic [VW-1:0] vl, input int bp, input int ignore_at);
        int exp_n, got, k, last_c, done_c;
        logic [AW-1:0] exp_a, prev_a;
        logic prev_stall;
        exp_n = (vl > 7'd64) ? 64 : int'(vl);
        got = 0; k = 0; last_c = -1; done_c = -100; prev_stall = 1'b0; prev_a = '0;
        @(negedge clk);
        mode = md; ewidth = ew; base = bs; stride = sd; vlen = vl; start = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 1000; c++) begin
            if (c == ignore_at) begin
                start = 1'b1; base = 32'h0BAD_0000; vlen = 7'd3; mode = 2'b01; stride = 32'd9;
            end else begin
                start = 1'b0;
            end
            addr_ready = (bp >= 1) ? ((c % 3) != 1) : 1'b1;
            idx_valid  = (bp == 2) ? ((c % 4) != 2) : 1'b1;
            idx_data   = idx_mem[(k < 64) ? k : 63];
            #1;
            if (prev_stall) begin
                chk(addr_valid && addr_out == prev_a, "R8", "held address", addr_out, prev_a);
            end
            if (md != 2'b10 && idx_ready) chk(1'b0, "R4", "idx_ready outside indexed", 1, 0);
            if (idx_ready && addr_valid) chk(1'b0, "R4", "idx_ready with addr_valid", 1, 0);
            if (done) begin
                done_c = c;
                break;
            end
            if (addr_valid && addr_ready) begin
                case (md)
                    2'b01:   exp_a = bs + AW'(got) * (sd << ew);
                    2'b10:   exp_a = bs + idx_mem[got];
                    default: exp_a = bs + (AW'(got) << ew);
                endcase
                chk(addr_out == exp_a, req, "address", addr_out, exp_a);
                chk(addr_elem == VW'(got), "R5", "element number", AW'(addr_elem), AW'(got));
                got++;
                last_c = c;
            end
            prev_stall = addr_valid && !addr_ready;
            prev_a = addr_out;
            if (idx_ready && idx_valid) k++;
            @(negedge clk);
        end
        start = 1'b0;
        addr_ready = 1'b0;
        idx_valid = 1'b0;
        chk(got == exp_n, "R5", "address count", AW'(got), AW'(exp_n));
        chk(done_c == last_c + 1, "R7", "done cycle", AW'(done_c), AW'(last_c + 1));
        @(negedge clk);
        chk(!done, "R7", "done width", AW'(done), 0);
        chk(!addr_valid && !idx_ready, "R9", "idle after done", AW'(addr_valid), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!addr_valid && !idx_ready && !done, "R1", "outputs in reset",
            AW'({addr_valid, idx_ready, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!addr_valid && !idx_ready && !done, "R1", "outputs after reset",
            AW'({addr_valid, idx_ready, done}), 0);
    endtask

    task automatic t_unit;
        run_case("R2", 2'b00, 2'd2, 32'h1000_0000, 32'd0, 7'd8, 0, -1);
        run_case("R2", 2'b00, 2'd0, 32'h0000_00F0, 32'd0, 7'd5, 1, -1);
        run_case("R2", 2'b00, 2'd3, 32'h0002_0000, 32'd0, 7'd64, 0, -1);
    endtask

    task automatic t_stride;
        run_case("R3", 2'b01, 2'd1, 32'h0000_4000, 32'd3, 7'd10, 0, -1);
        run_case("R3", 2'b01, 2'd2, 32'h0000_0010, 32'hFFFF_FFFE, 7'd6, 1, -1);
    endtask

    task automatic t_index;
        run_case("R4", 2'b10, 2'd2, 32'h0008_0000, 32'd0, 7'd12, 0, -1);
        run_case("R4", 2'b10, 2'd0, 32'h0000_0040, 32'd0, 7'd9, 2, -1);
    endtask

    task automatic t_zero;  run_case("R6", 2'b00, 2'd1, 32'h0000_1234, 32'd0, 7'd0, 0, -1); endtask
    task automatic t_clamp; run_case("R11", 2'b00, 2'd0, 32'h0000_0000, 32'd0, 7'd100, 0, -1); endtask
    task automatic t_alt;   run_case("R10", 2'b11, 2'd1, 32'h0000_0300, 32'd5, 7'd7, 0, -1); endtask
    task automatic t_busy;  run_case("R9", 2'b00, 2'd2, 32'h0000_8000, 32'd0, 7'd10, 1, 3); endtask
    task automatic t_one;   run_case("R7", 2'b01, 2'd3, 32'h0000_0100, 32'd4, 7'd1, 1, -1); endtask

    initial begin
        for (int i = 0; i < 64; i++) idx_mem[i] = AW'(i * i * 12) - 32'd100;
        t_reset();
        t_unit();
        t_stride();
        t_index();
        t_zero();
        t_clamp();
        t_alt();
        t_busy();
        t_one();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule